// File: doc/BRIEF.md
# Count/Compare Coprocessor Timer

This block holds a 32-bit Count register that advances once for every tick pulse, and a 32-bit Compare register. When an incremented Count lands on the Compare value, the block raises a level-held timer interrupt on one of eight interrupt lines. A 3-bit routing input picks that line at the moment of the event. Software reaches both registers through a small register port with a select bit, a write strobe and write data, and reads come back one cycle later.

A count-freeze input stops the counter and keeps its value, and no match can fire while it is set. The only way to drop the interrupt is to write Compare. A revision-2 enable input adds a timer-pending status flag. With the enable set, a match sets the flag and a Compare write clears it.

Top module: `cp0_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, Count reads 1, Compare reads 0, all eight interrupt lines are low and the status flag is low.
- R2: With freeze low, each cycle with `tick_en` high adds one to Count. Count wraps from 0xFFFFFFFF to 0.
- R3: While `count_freeze` is high, ticks leave Count unchanged. Once freeze drops, counting resumes from the held value.
- R4: A write with `reg_sel`=0 loads Count with `reg_wdata` whether freeze is set or not. In the same cycle it takes priority over a tick, and that cycle produces no match.
- R5: A match is a cycle with a tick, freeze low, no Count write, and Count+1 equal to Compare. A match sets `irq_lines[irq_route]`, which stays high until a Compare write. A Count write does not lower it.
- R6: While `count_freeze` is high no match occurs, so no interrupt line rises.
- R7: A write with `reg_sel`=1 stores `reg_wdata` in Compare and lowers `irq_lines[irq_route]`. With `rev2_en` high it also clears `ti_flag`. If a match falls in the same cycle, the write wins and nothing is set.
- R8: A match or a Compare write changes only the line selected by `irq_route` in that cycle. The other lines keep their state.
- R9: `ti_flag` is set by a match only while `rev2_en` is high. While `rev2_en` is low, `ti_flag` does not change.
- R10: `reg_rdata` shows, one cycle after a clock edge, the register chosen by `reg_sel` (0 gives Count, 1 gives Compare) as it stood before that edge's update.
- R11: With Compare at 0, a tick taking Count from 0xFFFFFFFF to 0 counts as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One timer tick per high cycle |
| count_freeze | input | 1 | Stops counting and matching while high |
| rev2_en | input | 1 | Enables the timer-pending status flag |
| irq_route | input | 3 | Selects which interrupt line a match or acknowledge affects |
| reg_sel | input | 1 | Register select: 0 Count, 1 Compare |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| irq_lines | output | 8 | Level interrupt lines |
| ti_flag | output | 1 | Timer-pending status flag |

## Verification
A wrong Count value shows up at `reg_rdata` on the cycle after the bench reads Count. It also shows up as a misplaced interrupt edge, which appears on `irq_lines` one cycle after the tick that should, or should not, have matched. A line that was wrongly set or cleared, including one off the routed index, differs on the very next cycle. A stuck status flag is exposed on the first match or Compare write that should have moved it. The reference model is compared against all three outputs on every clock, so a divergence is seen within one cycle of becoming observable.

// File: rtl/cp0t_pkg.sv
// Shared constants for the count/compare timer.
// Assumes a single-bit register select on the software port.
package cp0t_pkg;
    localparam logic SEL_COUNT = 1'b0;
    localparam logic SEL_CMP   = 1'b1;
endpackage

// File: rtl/cp0t_count_reg.sv
// Count register with tick advance, freeze, software load and match detect.
// Assumes: load has priority over a tick; match is a single-cycle pulse
// computed against the incremented value and the stored compare value.
module cp0t_count_reg #(
    parameter int unsigned    DATA_W      = 32,
    parameter logic [DATA_W-1:0] RESET_COUNT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              freeze,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] count_q,
    output logic              match
);
    logic              step;
    logic [DATA_W-1:0] count_inc;

    // Decide whether this cycle advances and what the advanced value is.
    always_comb begin
        step      = tick_en && !freeze;
        count_inc = count_q + {{(DATA_W-1){1'b0}}, 1'b1};
        match     = step && !load && (count_inc == cmp_val);
    end

    // Hold, load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= RESET_COUNT;
        else if (load)  count_q <= load_val;
        else if (step)  count_q <= count_inc;
    end
endmodule

// File: rtl/cp0t_irq_route.sv
// Per-line interrupt state and timer-pending status flag.
// Assumes: clear (compare write) beats set (match); only the routed line moves.
module cp0t_irq_route #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned ROUTE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROUTE_W-1:0] route,
    input  logic               set_evt,
    input  logic               clr_evt,
    input  logic               rev2_en,
    output logic [N_LINES-1:0] lines_q,
    output logic               ti_q
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic hit;
        // Is this line the one currently routed?
        always_comb hit = (route == ROUTE_W'(i));

        // Set on a routed match, drop on a routed acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                lines_q[i] <= 1'b0;
            else if (hit && clr_evt)   lines_q[i] <= 1'b0;
            else if (hit && set_evt)   lines_q[i] <= 1'b1;
        end
    end

    // Status flag follows set/clear only when the revision-2 feature is on.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ti_q <= 1'b0;
        else if (rev2_en && clr_evt)  ti_q <= 1'b0;
        else if (rev2_en && set_evt)  ti_q <= 1'b1;
    end
endmodule

// File: rtl/cp0_tick_timer.sv
// Count/compare timer top: compare register, register port decode,
// registered read mux, counter and interrupt routing.
// Assumes one register access per cycle and read latency of one cycle.
module cp0_tick_timer #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_LINES = 8,
    localparam int unsigned ROUTE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               count_freeze,
    input  logic               rev2_en,
    input  logic [ROUTE_W-1:0] irq_route,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [N_LINES-1:0] irq_lines,
    output logic               ti_flag
);
    import cp0t_pkg::*;

    logic              count_wr;
    logic              cmp_wr;
    logic              match;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] cmp_q;

    // Decode the register port strobes.
    always_comb begin
        count_wr = reg_we && (reg_sel == SEL_COUNT);
        cmp_wr   = reg_we && (reg_sel == SEL_CMP);
    end

    cp0t_count_reg #(.DATA_W(DATA_W), .RESET_COUNT(DATA_W'(1))) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .freeze  (count_freeze),
        .load    (count_wr),
        .load_val(reg_wdata),
        .cmp_val (cmp_q),
        .count_q (count_q),
        .match   (match)
    );

    // Compare register, reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= reg_wdata;
    end

    cp0t_irq_route #(.N_LINES(N_LINES)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .route  (irq_route),
        .set_evt(match),
        .clr_evt(cmp_wr),
        .rev2_en(rev2_en),
        .lines_q(irq_lines),
        .ti_q   (ti_flag)
    );

    // Registered read of the selected register's pre-update value.
    always_ff @(posedge clk) begin
        if (!rst_n)                  reg_rdata <= '0;
        else if (reg_sel == SEL_CMP) reg_rdata <= cmp_q;
        else                         reg_rdata <= count_q;
    end
endmodule

// File: rtl/cp0t_timer_chk.sv
// Property checker for cp0_tick_timer, attached by bind below.
module cp0t_timer_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned N_LINES = 8,
    localparam int unsigned ROUTE_W = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               count_freeze,
    input logic               rev2_en,
    input logic [ROUTE_W-1:0] irq_route,
    input logic               reg_sel,
    input logic               reg_we,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [N_LINES-1:0] irq_lines,
    input logic               ti_flag,
    input logic [DATA_W-1:0]  count_q,
    input logic [DATA_W-1:0]  cmp_q
);
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !count_freeze && !reg_we) |=>
        (count_q == $past(count_q) + {{(DATA_W-1){1'b0}}, 1'b1}));

    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_freeze && !(reg_we && !reg_sel)) |=> (count_q == $past(count_q)));

    p_frozen_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_freeze && !(reg_we && reg_sel)) |=> (irq_lines == $past(irq_lines)));

    p_cmp_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> !irq_lines[$past(irq_route)]);

    p_single_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(irq_lines ^ $past(irq_lines)) <= 1));

    p_legacy_ti_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rev2_en |=> (ti_flag == $past(ti_flag)));

    p_read_cmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |=> (reg_rdata == $past(cmp_q)));
endmodule

bind cp0_tick_timer cp0t_timer_chk #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .count_freeze(count_freeze),
    .rev2_en     (rev2_en),
    .irq_route   (irq_route),
    .reg_sel     (reg_sel),
    .reg_we      (reg_we),
    .reg_rdata   (reg_rdata),
    .irq_lines   (irq_lines),
    .ti_flag     (ti_flag),
    .count_q     (count_q),
    .cmp_q       (cmp_q)
);

// File: tb/cp0_tick_timer_bench.sv
module cp0_tick_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, count_freeze, rev2_en, reg_sel, reg_we;
    logic [2:0]  irq_route;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_lines;
    logic        ti_flag;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;
    bit m_live = 0;

    // Behavioural reference state.
    logic [31:0] m_count, m_cmp, m_rdata;
    logic [7:0]  m_lines;
    logic        m_ti;

    always #(CLK_PERIOD/2) clk = ~clk;

    cp0_tick_timer u_cp0_tick_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count_freeze(count_freeze),
        .rev2_en(rev2_en), .irq_route(irq_route), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
        .ti_flag(ti_flag)
    );

    // Reference model: advance on each rising edge from the held inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 32'd1; m_cmp = 32'd0; m_rdata = 32'd0;
            m_lines = 8'd0;  m_ti = 1'b0;   m_live = 1;
        end else begin
            logic [31:0] c0, k0;
            bit hit;
            c0 = m_count; k0 = m_cmp;
            m_rdata = reg_sel ? k0 : c0;
            hit = tick_en && !count_freeze && !(reg_we && !reg_sel) && (c0 + 32'd1 == k0);
            if (reg_we && !reg_sel) m_count = reg_wdata;
            else if (tick_en && !count_freeze) m_count = c0 + 32'd1;
            if (reg_we && reg_sel) begin
                m_cmp = reg_wdata;
                m_lines[irq_route] = 1'b0;
                if (rev2_en) m_ti = 1'b0;
            end else if (hit) begin
                m_lines[irq_route] = 1'b1;
                if (rev2_en) m_ti = 1'b1;
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (m_live && rst_n && !done) begin
            chk(reg_rdata, m_rdata, "R10 rdata vs model");
            chk({24'd0, irq_lines}, {24'd0, m_lines}, "R8 lines vs model");
            chk({31'd0, ti_flag}, {31'd0, m_ti}, "R9 flag vs model");
        end
    end

    task automatic drive(input logic tk, input logic dc, input logic we,
                         input logic sl, input logic [31:0] d);
        tick_en = tk; count_freeze = dc; reg_we = we; reg_sel = sl; reg_wdata = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; rev2_en = 1; irq_route = 3'd3;
        tick_en = 0; count_freeze = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        drive(0, 0, 0, 0, 0);
        chk(reg_rdata, 32'd1, "R1 count after reset");
        chk({24'd0, irq_lines}, 32'd0, "R1 lines after reset");
        chk({31'd0, ti_flag}, 32'd0, "R1 flag after reset");
        drive(0, 0, 0, 1, 0);
        chk(reg_rdata, 32'd0, "R1 compare after reset");
        // R2: four ticks
        repeat (4) drive(1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk(reg_rdata, 32'd5, "R2 count after ticks");
        // R5: match on line 3
        drive(0, 0, 1, 1, 32'd8);
        repeat (3) drive(1, 0, 0, 0, 0);
        chk({24'd0, irq_lines}, 32'h08, "R5 line 3 set");
        chk({31'd0, ti_flag}, 32'd1, "R9 flag set with rev2");
        drive(0, 0, 1, 0, 32'd100);
        chk({24'd0, irq_lines}, 32'h08, "R5 count write keeps line");
        // R8: second line via route 5
        irq_route = 3'd5;
        repeat (2) drive(1, 0, 0, 0, 0);
        drive(0, 0, 1, 1, 32'd104);
        repeat (2) drive(1, 0, 0, 0, 0);
        chk({24'd0, irq_lines}, 32'h28, "R8 two lines held");
        irq_route = 3'd3;
        drive(0, 0, 1, 1, 32'd0);
        chk({24'd0, irq_lines}, 32'h20, "R8 only routed line cleared");
        chk({31'd0, ti_flag}, 32'd0, "R7 flag cleared by compare write");
        // R7: same-cycle compare write beats match
        irq_route = 3'd5;
        drive(0, 0, 1, 0, 32'hFFFF_FFFE);
        drive(1, 0, 0, 0, 0);
        drive(1, 0, 1, 1, 32'd50);
        chk({24'd0, irq_lines}, 32'h00, "R7 write wins over match");
        drive(0, 0, 0, 1, 0);
        chk(reg_rdata, 32'd50, "R7 compare stored");
        // R11: wrap match
        drive(0, 0, 1, 1, 32'd0);
        drive(0, 0, 1, 0, 32'hFFFF_FFFF);
        drive(1, 0, 0, 0, 0);
        chk({24'd0, irq_lines}, 32'h20, "R11 wrap match");
        drive(0, 0, 0, 0, 0);
        chk(reg_rdata, 32'd0, "R2 wrap to zero");
        // R3/R4/R6: freeze
        irq_route = 3'd1;
        drive(0, 0, 1, 1, 32'd10);
        drive(0, 1, 1, 0, 32'd9);
        repeat (3) drive(1, 1, 0, 0, 0);
        chk({24'd0, irq_lines}, 32'h20, "R6 no match while frozen");
        drive(0, 1, 0, 0, 0);
        chk(reg_rdata, 32'd9, "R3 R4 count held after frozen load");
        drive(1, 0, 0, 0, 0);
        chk({24'd0, irq_lines}, 32'h22, "R3 resume and match");
        drive(0, 0, 0, 0, 0);
        chk(reg_rdata, 32'd10, "R3 resumed value");
        // R9: legacy mode leaves flag alone
        rev2_en = 0; irq_route = 3'd2;
        drive(0, 0, 1, 1, 32'd20);
        chk({31'd0, ti_flag}, 32'd1, "R9 flag kept without rev2");
        drive(0, 0, 1, 0, 32'd19);
        drive(1, 0, 0, 0, 0);
        chk({24'd0, irq_lines}, 32'h26, "R5 legacy match sets line");
        // Mixed random traffic, checked against the model each clock.
        for (int k = 0; k < 3000; k++) begin
            rev2_en   = ($urandom_range(0, 3) != 0);
            irq_route = 3'($urandom_range(0, 7));
            drive(($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0),
                  ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
                  m_count + 32'($urandom_range(0, 6)));
        end
        finish_run();
    end
endmodule